// File: doc/BRIEF.md
# CPU Bus Memory Strobe Generator

This block turns the raw signals of a 68000-style bus into the active-low strobes that memory devices need. The inputs are a 24-bit byte address, the address strobe, the upper and lower data strobes, a read/write line (1 = read) and a flag saying that a DMA engine, not the CPU, owns the bus. The outputs are a cartridge read strobe, a work-RAM chip select, a work-RAM output enable, two byte-lane write strobes, and a busy flag.

The address windows differ by bus owner. Under CPU control the cartridge read strobe covers everything below the RAM area at 0xE00000, and the RAM signals cover 0xE00000 and up. Under DMA the cartridge read strobe and the RAM output enable cover the whole 16 MB space, and the RAM select covers 0x800000 and up. A free-running timer raises a refresh request for the pseudo-static work RAM. The next RAM select cycle is then held back for three clocks, during which the chip select stays high and one extra output-enable pulse is placed in the middle clock. Busy is high for all three clocks so that the data acknowledge can be delayed.

The refresh controller has four states. IDLE waits for a RAM cycle. On a RAM request with no refresh pending it goes straight to GRANT. On a RAM request with a refresh pending it spends that first clock stalled and moves to REF_PULSE. REF_PULSE always goes to REF_TAIL, and REF_TAIL always goes to GRANT. GRANT holds while the RAM request lasts and returns to IDLE when the request drops.

Top module: `membus_strobe_gen`

## Requirements
- R1: `uwr_n` is low exactly when `uds_n` is low and `rw` is 0 (write), and `lwr_n` is low exactly when `lds_n` is low and `rw` is 0. The address strobe and the bus owner have no effect on them.
- R2: With `dma_act` = 0, `rom_rd_n` is low exactly when `as_n` is low, `rw` is 1, and `addr` is in 0x000000–0xDFFFFF.
- R3: With `dma_act` = 1, `rom_rd_n` is low exactly when `as_n` is low and `rw` is 1, at any address.
- R4: With `dma_act` = 0 and no refresh stall, `ram_cs_n` is low in the same cycle that `as_n` is low with `addr` in 0xE00000–0xFFFFFF, and it is high for lower addresses.
- R5: With `dma_act` = 1 and no refresh stall, `ram_cs_n` is low whenever `as_n` is low with `addr` in 0x800000–0xFFFFFF. This holds for reads and writes.
- R6: Outside a refresh, `ram_oe_n` is low whenever `rw` is 1 and `addr` is in 0xE00000–0xFFFFFF (CPU), or whenever `rw` is 1 at any address (DMA). It does not depend on `as_n`.
- R7: A refresh request is raised once every 128 clocks after reset and stays pending until a RAM select cycle starts. That cycle services it and clears it, so the next RAM cycle is not stalled.
- R8: A RAM cycle that starts with a refresh pending keeps `ram_cs_n` high for its first three clocks. `ram_oe_n` is high, low, high across those three clocks, and `ram_cs_n` goes low on the fourth.
- R9: `busy` is high for exactly the three stall clocks of a refresh, and `ram_cs_n` is never low while `busy` is high.
- R10: While `rst_n` is low with `as_n`, `uds_n` and `lds_n` high and `rw` = 0, all strobes are high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 24 | Byte address of the current bus cycle |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| dma_act | input | 1 | 1 when DMA owns the bus |
| rom_rd_n | output | 1 | Cartridge read strobe, active low |
| ram_cs_n | output | 1 | Work-RAM chip select, active low |
| ram_oe_n | output | 1 | Work-RAM output enable, active low |
| uwr_n | output | 1 | Upper byte-lane write strobe, active low |
| lwr_n | output | 1 | Lower byte-lane write strobe, active low |
| busy | output | 1 | High during a refresh stall |

## Verification
The bench probes the window edges on both sides: 0xDFFFFE against 0xE00000 under the CPU, and 0x7FFFFE against 0x800000 under DMA. A design with the wrong base, or with the CPU and DMA windows swapped, would drive the cartridge and the RAM together or leave an access with no strobe. A separate vector drops the address strobe during a RAM-area read. A design that gated the output enable with the address strobe would leave it high there.

The refresh test waits for the request and then follows one RAM cycle clock by clock. A design that let the chip select through in the first clock, put the extra pulse in the wrong clock, or stretched by the wrong count would show up on `ram_cs_n`, `ram_oe_n` or `busy`. An immediate second RAM cycle must run with no stall. A design that never cleared the request would stall it.

// File: rtl/membus_pkg.sv
package membus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REF_PULSE = 2'd1,
        ST_REF_TAIL  = 2'd2,
        ST_GRANT     = 2'd3
    } ref_state_e;

endpackage

// File: rtl/strobe_decode.sv
module strobe_decode #(
    parameter int          ADDR_W       = 24,
    parameter logic [23:0] CPU_RAM_BASE = 24'hE00000,
    parameter logic [23:0] DMA_RAM_BASE = 24'h800000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rw,
    input  logic              dma_act,
    output logic              rom_req,
    output logic              ram_req,
    output logic              oe_req,
    output logic              uwr_n,
    output logic              lwr_n
);

    localparam logic [ADDR_W-1:0] CPU_BASE = ADDR_W'(CPU_RAM_BASE);
    localparam logic [ADDR_W-1:0] DMA_BASE = ADDR_W'(DMA_RAM_BASE);

    logic in_cpu_ram;
    logic in_dma_ram;

    always_comb begin
        in_cpu_ram = (addr >= CPU_BASE);
        in_dma_ram = (addr >= DMA_BASE);

        // The cartridge window is the whole space under DMA, and below the RAM area otherwise
        rom_req = !as_n && rw && (dma_act || !in_cpu_ram);
        ram_req = !as_n && (dma_act ? in_dma_ram : in_cpu_ram);
        oe_req  = rw && (dma_act || in_cpu_ram);

        uwr_n   = !(!uds_n && !rw);
        lwr_n   = !(!lds_n && !rw);
    end

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int PERIOD = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic pend
);

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    // R7: a raised request is held until a RAM cycle takes it
    a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    // R7: a request is cleared when it is taken
    a_r7_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr && !wrap) |=> !pend);

endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
    import membus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ram_req,
    input  logic pend,
    output logic ref_clr,
    output logic stall,
    output logic pulse,
    output logic cs_allow
);

    ref_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ram_req)
                    state_nxt = pend ? ST_REF_PULSE : ST_GRANT;
            end
            ST_REF_PULSE: state_nxt = ST_REF_TAIL;
            ST_REF_TAIL:  state_nxt = ST_GRANT;
            ST_GRANT: begin
                if (!ram_req)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ref_clr  = 1'b0;
        stall    = 1'b0;
        pulse    = 1'b0;
        cs_allow = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ref_clr  = ram_req && pend;
                stall    = ram_req && pend;
                cs_allow = !pend;
            end
            ST_REF_PULSE: begin
                stall = 1'b1;
                pulse = 1'b1;
            end
            ST_REF_TAIL:  stall = 1'b1;
            ST_GRANT:     cs_allow = 1'b1;
            default: ;
        endcase
    end

    // R8: the pulse clock is always followed by the tail clock
    a_r8_pulse_to_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF_PULSE) |=> (state == ST_REF_TAIL));

    // R8: the tail clock always ends in a granted cycle
    a_r8_tail_to_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REF_TAIL) |=> (state == ST_GRANT));

endmodule

// File: rtl/membus_strobe_gen.sv
module membus_strobe_gen #(
    parameter int          ADDR_W         = 24,
    parameter int          REFRESH_PERIOD = 128,
    parameter logic [23:0] CPU_RAM_BASE   = 24'hE00000,
    parameter logic [23:0] DMA_RAM_BASE   = 24'h800000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rw,
    input  logic              dma_act,
    output logic              rom_rd_n,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              uwr_n,
    output logic              lwr_n,
    output logic              busy
);

    logic rom_req, ram_req, oe_req;
    logic pend, ref_clr, stall, pulse, cs_allow;

    strobe_decode #(
        .ADDR_W      (ADDR_W),
        .CPU_RAM_BASE(CPU_RAM_BASE),
        .DMA_RAM_BASE(DMA_RAM_BASE)
    ) u_dec (
        .addr   (addr),
        .as_n   (as_n),
        .uds_n  (uds_n),
        .lds_n  (lds_n),
        .rw     (rw),
        .dma_act(dma_act),
        .rom_req(rom_req),
        .ram_req(ram_req),
        .oe_req (oe_req),
        .uwr_n  (uwr_n),
        .lwr_n  (lwr_n)
    );

    refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ref_clr),
        .pend (pend)
    );

    refresh_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ram_req (ram_req),
        .pend    (pend),
        .ref_clr (ref_clr),
        .stall   (stall),
        .pulse   (pulse),
        .cs_allow(cs_allow)
    );

    assign rom_rd_n = !rom_req;
    assign ram_cs_n = !(ram_req && cs_allow);
    assign ram_oe_n = !(pulse || (oe_req && !stall));
    assign busy     = stall;

    // R9: the RAM is never selected during a refresh stall
    a_r9_busy_blocks_cs: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ram_cs_n);

    // R2: under CPU control the cartridge and the RAM are never selected together
    a_r2_rom_ram_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_act && !as_n) |-> (rom_rd_n || ram_cs_n));

    // R8: the output enable rises again in the clock after the extra pulse
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ram_oe_n) |=> ram_oe_n);

endmodule

// File: tb/sim_membus_strobe_gen.sv
module sim_membus_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b0, dma_act = 1'b0;
    logic        rom_rd_n, ram_cs_n, ram_oe_n, uwr_n, lwr_n, busy;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    membus_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .uds_n(uds_n),
        .lds_n(lds_n), .rw(rw), .dma_act(dma_act), .rom_rd_n(rom_rd_n),
        .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .uwr_n(uwr_n), .lwr_n(lwr_n),
        .busy(busy)
    );

    typedef struct packed {
        logic        dma;
        logic        as_n;
        logic        rw;
        logic        uds_n;
        logic        lds_n;
        logic [23:0] addr;
        logic [4:0]  exp;   // {rom_rd_n, ram_cs_n, ram_oe_n, uwr_n, lwr_n}
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'h000100, 5'b01111},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'hDFFFFE, 5'b01111},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'hE00000, 5'b10011},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'hFFFFFE, 5'b10011},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'hE00010, 5'b10100},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 24'hC00000, 5'b11101},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000000, 5'b11110},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 24'h800000, 5'b00011},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 24'h7FFFFE, 5'b01011},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 24'hFFFFFE, 5'b00011},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'h800000, 5'b01111},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'hE00000, 5'b11011},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h900000, 5'b10100}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1, 10: return "R2 R4";
            2, 3:     return "R4 R6";
            4, 5, 6:  return "R1";
            7, 9:     return "R3 R5 R6";
            8:        return "R3 R6";
            11:       return "R6";
            default:  return "R5 R1";
        endcase
    endfunction

    task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {rom,cs,oe,uwr,lwr,busy} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {rom_rd_n, ram_cs_n, ram_oe_n, uwr_n, lwr_n, busy};
    endfunction

    task automatic idle_bus();
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw = 1'b0; dma_act = 1'b0;
    endtask

    task automatic ram_read();
        dma_act = 1'b0; as_n = 1'b0; rw = 1'b1; uds_n = 1'b0; lds_n = 1'b0;
        addr = 24'hE00100;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1 chk("R10", outs(), 6'b111110);
        @(negedge clk);
        rst_n = 1'b1;

        // Decode table, run while no refresh can be pending (R7 period 128)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            dma_act = VECS[i].dma; as_n = VECS[i].as_n; rw = VECS[i].rw;
            uds_n = VECS[i].uds_n; lds_n = VECS[i].lds_n; addr = VECS[i].addr;
            #1 chk(vtag(i), outs(), {VECS[i].exp, 1'b0});
            @(negedge clk);
            idle_bus();
        end

        // Let the refresh request rise (R7), then run a RAM read through the stall
        repeat (120) @(negedge clk);
        ram_read();
        #1 chk("R8 R9 stall1", outs(), 6'b111111);
        @(negedge clk); #1 chk("R8 R9 pulse", outs(), 6'b110111);
        @(negedge clk); #1 chk("R8 R9 tail", outs(), 6'b111111);
        @(negedge clk); #1 chk("R8 R9 grant", outs(), 6'b100110);
        @(negedge clk); #1 chk("R8 hold", outs(), 6'b100110);
        @(negedge clk);
        idle_bus();
        @(negedge clk);
        // R7: the request was consumed, so the next cycle runs at once
        ram_read();
        #1 chk("R7 no second stall", outs(), 6'b100110);
        @(negedge clk);
        idle_bus();

        // R7: a new request arrives one period later and stalls a DMA write
        repeat (135) @(negedge clk);
        dma_act = 1'b1; as_n = 1'b0; rw = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        addr = 24'h900000;
        #1 chk("R7 R9 dma stall", outs(), 6'b111001);
        @(negedge clk); #1 chk("R8 dma pulse", outs(), 6'b110001);
        @(negedge clk); #1 chk("R8 dma tail", outs(), 6'b111001);
        @(negedge clk); #1 chk("R5 dma grant", outs(), 6'b101000);
        @(negedge clk);
        idle_bus();

        // R10: reset in the middle of a cycle drops everything
        @(negedge clk);
        ram_read();
        @(negedge clk);
        rst_n = 1'b0;
        idle_bus();
        #1 chk("R10 re-reset", outs(), 6'b111110);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule